// File: doc/BRIEF.md
# Successive Approximation Read Controller for a Comparator-Output Sensor

This block runs on the host side. It reads an 8-bit pressure or temperature value from a sensor that has no data converter of its own and only reports one comparator bit. A start request and a channel select begin a conversion. The controller then drives the sensor's two mode pins to the chosen measurement mode and keeps them there for that channel's measurement time. After that it moves the sensor into output-read mode and waits for the comparator output to become valid.

It then performs a binary search over eight trials. In each trial it sends an 8-bit threshold to the sensor over a clock line and a data line. It waits for the comparator to settle and samples the comparator bit, which tells it whether to keep the bit under test. When all eight trials are done, it returns the mode pins to standby, presents the final code and raises a one-cycle done flag.

Every interval is a parameter counted in system-clock cycles. The integrator chooses the values so that they meet the sensor's timing at the actual clock rate.

Top module: `sar_sense_ctrl`

## Requirements
- R1: A start seen in idle with `chan_i`=0 drives pressure measurement (`mode_p_o`=1, `mode_t_o`=0) for MEAS_P_CYC cycles. With `chan_i`=1 it drives temperature measurement (`mode_p_o`=0, `mode_t_o`=1) for MEAS_T_CYC cycles. The first such cycle follows the clock edge that sampled the start.
- R2: Straight after measurement, both mode pins go high (output-read mode) and stay high until the conversion ends. The first READ_WAIT_CYC cycles of that mode keep `sck_o` and `sdo_o` low.
- R3: Each threshold upload sends 8 bits, bit 7 first. For each bit, `sdo_o` carries the bit for HALF_CYC cycles with `sck_o` low and then for HALF_CYC more cycles with `sck_o` high. `sdo_o` never changes while `sck_o` is high. `sck_o` is never high outside output-read mode.
- R4: After each upload, `sck_o` and `sdo_o` stay low for SETTLE_CYC cycles. `cmp_i` is sampled on the clock edge that ends this wait.
- R5: Trial k (k=0..7) tests bit 7-k. Its threshold is the bits kept so far with the tested bit set. The tested bit is kept when `cmp_i`=1, meaning the sample is at or above the threshold. The value after the eighth trial becomes `code_o`.
- R6: A conversion ends with exactly one cycle in which `done_o`=1, `busy_o`=0 and both mode pins are 0. `code_o` takes its new value in that cycle and holds it until the next done cycle.
- R7: A start that arrives while `busy_o`=1, or during the done cycle, is ignored.
- R8: During reset and in idle, all outputs are 0. `code_o` is 0 until the first conversion ends.
- R9: `busy_o` stays high for exactly MEAS + READ_WAIT_CYC + 8*(16*HALF_CYC + SETTLE_CYC) cycles, where MEAS is the measurement time of the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| chan_i | input | 1 | 0 = pressure, 1 = temperature |
| cmp_i | input | 1 | Sensor comparator bit, 1 = sample at or above threshold |
| mode_p_o | output | 1 | Sensor mode pin for pressure measurement |
| mode_t_o | output | 1 | Sensor mode pin for temperature measurement |
| sck_o | output | 1 | Threshold serial clock |
| sdo_o | output | 1 | Threshold serial data |
| code_o | output | 8 | Last conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The assertions relate only the block's outputs to one another. They take for granted that reset is held low from time zero until the clock has ticked, so every register starts from a known value. They put no condition on `cmp_i`, and the checker stays valid whatever the sensor answers. The stimulus keeps within this by holding reset from the first instant. It changes `start_i` only between clock edges. It drives `cmp_i` from a sensor model that compares a captured sample against the threshold latched on the eighth falling clock edge, so the comparator bit changes only while the controller is waiting out the settle time.

// File: rtl/sar_sense_ctrl.sv
module sar_sense_ctrl #(
  parameter int MEAS_P_CYC    = 25000,
  parameter int MEAS_T_CYC    = 10000,
  parameter int READ_WAIT_CYC = 5000,
  parameter int HALF_CYC      = 5,
  parameter int SETTLE_CYC    = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       chan_i,
  input  logic       cmp_i,
  output logic       mode_p_o,
  output logic       mode_t_o,
  output logic       sck_o,
  output logic       sdo_o,
  output logic [7:0] code_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int M1   = (MEAS_P_CYC > MEAS_T_CYC) ? MEAS_P_CYC : MEAS_T_CYC;
  localparam int M2   = (M1 > READ_WAIT_CYC) ? M1 : READ_WAIT_CYC;
  localparam int M3   = (M2 > HALF_CYC) ? M2 : HALF_CYC;
  localparam int MAXC = (M3 > SETTLE_CYC) ? M3 : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {IDLE, MEAS, RWAIT, SHIFT, SETTLE, FIN} st_t;

  st_t         st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  bit_q, trial_q;
  logic        hi_q, chan_q;
  logic [7:0]  acc_q, code_q, thr;
  logic        rd;

  assign thr      = acc_q | (8'h80 >> trial_q);
  assign rd       = (st_q == RWAIT) || (st_q == SHIFT) || (st_q == SETTLE);
  assign mode_p_o = rd || (st_q == MEAS && !chan_q);
  assign mode_t_o = rd || (st_q == MEAS && chan_q);
  assign sck_o    = (st_q == SHIFT) && hi_q;
  assign sdo_o    = (st_q == SHIFT) && thr[bit_q];
  assign busy_o   = (st_q != IDLE) && (st_q != FIN);
  assign done_o   = (st_q == FIN);
  assign code_o   = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cnt_q   <= '0;
      bit_q   <= 3'd7;
      trial_q <= 3'd0;
      hi_q    <= 1'b0;
      chan_q  <= 1'b0;
      acc_q   <= 8'd0;
      code_q  <= 8'd0;
    end else begin
      case (st_q)
        IDLE: if (start_i) begin
          st_q    <= MEAS;
          chan_q  <= chan_i;
          cnt_q   <= chan_i ? CW'(MEAS_T_CYC - 1) : CW'(MEAS_P_CYC - 1);
          acc_q   <= 8'd0;
          trial_q <= 3'd0;
        end
        MEAS: if (cnt_q == 0) begin
          st_q  <= RWAIT;
          cnt_q <= CW'(READ_WAIT_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        RWAIT: if (cnt_q == 0) begin
          st_q  <= SHIFT;
          cnt_q <= CW'(HALF_CYC - 1);
          bit_q <= 3'd7;
          hi_q  <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        SHIFT: if (cnt_q == 0) begin
          cnt_q <= CW'(HALF_CYC - 1);
          hi_q  <= !hi_q;
          if (hi_q) begin
            if (bit_q == 0) begin
              st_q  <= SETTLE;
              cnt_q <= CW'(SETTLE_CYC - 1);
            end else bit_q <= bit_q - 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        SETTLE: if (cnt_q == 0) begin
          if (cmp_i) acc_q <= thr;
          if (trial_q == 3'd7) begin
            st_q   <= FIN;
            code_q <= cmp_i ? thr : acc_q;
          end else begin
            trial_q <= trial_q + 1'b1;
            st_q    <= SHIFT;
            bit_q   <= 3'd7;
            hi_q    <= 1'b0;
            cnt_q   <= CW'(HALF_CYC - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= IDLE;
      endcase
    end
  end
endmodule

module sar_sense_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_p_o,
  input logic       mode_t_o,
  input logic       sck_o,
  input logic       sdo_o,
  input logic [7:0] code_o,
  input logic       busy_o,
  input logic       done_o
);
  AST_SCK_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> (mode_p_o && mode_t_o)); // R3
  AST_SDO_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> $stable(sdo_o)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !mode_p_o && !mode_t_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mode_p_o && !mode_t_o && !sck_o && !sdo_o)); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o)); // R6
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_p_o && mode_t_o) && busy_o) |-> (mode_p_o && mode_t_o)); // R2
endmodule

bind sar_sense_ctrl sar_sense_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_p_o(mode_p_o), .mode_t_o(mode_t_o),
  .sck_o(sck_o), .sdo_o(sdo_o), .code_o(code_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sar_sense_ctrl_tb.sv
module sar_sense_ctrl_tb;
  localparam int MP = 40, MT = 20, RW = 10, HC = 2, SC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, chan_i = 1'b0, cmp_i;
  logic mode_p_o, mode_t_o, sck_o, sdo_o, busy_o, done_o;
  logic [7:0] code_o;

  always #10 clk = ~clk;

  sar_sense_ctrl #(.MEAS_P_CYC(MP), .MEAS_T_CYC(MT), .READ_WAIT_CYC(RW),
                   .HALF_CYC(HC), .SETTLE_CYC(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .cmp_i(cmp_i),
    .mode_p_o(mode_p_o), .mode_t_o(mode_t_o), .sck_o(sck_o), .sdo_o(sdo_o),
    .code_o(code_o), .busy_o(busy_o), .done_o(done_o));

  // sensor model
  logic [7:0] p_val = 8'd0, t_val = 8'd0, held = 8'd0, sh = 8'd0, dar = 8'd0;
  int nbits = 0;
  logic sck_prev = 1'b0;
  assign cmp_i = mode_p_o && mode_t_o && (held >= dar);
  always @(negedge clk) begin
    if (mode_p_o && !mode_t_o) begin held = p_val; nbits = 0; end
    if (!mode_p_o && mode_t_o) begin held = t_val; nbits = 0; end
    if (sck_o && !sck_prev) begin sh = {sh[6:0], sdo_o}; nbits++; end
    if (!sck_o && sck_prev && nbits == 8) begin dar = sh; nbits = 0; end
    sck_prev = sck_o;
  end

  int total = 0, bad = 0;
  bit finished = 0;
  logic [13:0] q[$];
  string tq[$];
  logic [7:0] last_code = 8'd0;
  string idle_tag = "R8";
  int busy_cnt = 0;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input int n, input logic mp, input logic mt, input logic sk,
                      input logic sd, input logic bz, input logic dn,
                      input logic [7:0] cd, input string tag);
    for (int i = 0; i < n; i++) begin
      q.push_back({mp, mt, sk, sd, bz, dn, cd});
      tq.push_back(tag);
    end
  endtask

  task automatic tick();
    logic [13:0] e;
    string tag;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); tag = tq.pop_front(); end
    else begin e = {6'b0, last_code}; tag = idle_tag; end
    chk(mode_p_o, e[13], tag, "mode_p");
    chk(mode_t_o, e[12], tag, "mode_t");
    chk(sck_o, e[11], tag, "sck");
    chk(sdo_o, e[10], tag, "sdo");
    chk(busy_o, e[9], tag, "busy");
    chk(done_o, e[8], tag, "done");
    chk(code_o, e[7:0], tag, "code");
    if (busy_o) busy_cnt++;
  endtask

  task automatic build(input logic ch, input logic [7:0] v);
    logic [7:0] acc = 8'd0, th;
    push(ch ? MT : MP, !ch, ch, 0, 0, 1, 0, last_code, "R1");
    push(RW, 1, 1, 0, 0, 1, 0, last_code, "R2");
    for (int k = 0; k < 8; k++) begin
      th = acc | (8'h80 >> k);
      for (int b = 7; b >= 0; b--) begin
        push(HC, 1, 1, 0, th[b], 1, 0, last_code, "R3");
        push(HC, 1, 1, 1, th[b], 1, 0, last_code, "R3");
      end
      push(SC, 1, 1, 0, 0, 1, 0, last_code, "R4");
      if (v >= th) acc = th;
    end
    push(1, 0, 0, 0, 0, 0, 1, acc, "R6");
    last_code = acc;
  endtask

  task automatic conv(input logic ch, input logic [7:0] v, input int poke_at, input bit poke_done);
    int n = 0;
    if (ch) t_val = v; else p_val = v;
    chan_i = ch;
    start_i = 1'b1;
    build(ch, v);
    busy_cnt = 0;
    tick();
    start_i = 1'b0;
    while (q.size() > 0) begin
      n++;
      start_i = (n == poke_at);
      chan_i = (n == poke_at) ? !ch : ch;
      tick();
      start_i = 1'b0;
    end
    chk(code_o, v, "R5", "final code");
    chk(busy_cnt, (ch ? MT : MP) + RW + 8 * (16 * HC + SC), "R9", "busy length");
    idle_tag = "R7";
    if (poke_done) start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick();
    idle_tag = "R8";
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    tick();
    conv(0, 8'd0, 0, 0);
    conv(0, 8'd255, 0, 0);
    conv(0, 8'h80, 50, 0);
    conv(0, 8'h7F, 0, 1);
    conv(1, 8'hA5, 120, 0);
    conv(1, 8'd1, 0, 1);
    conv(1, 8'h5A, 0, 0);
    repeat (3) tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired R9 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule